// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Controller

This block is the device-side end of message-signalled interrupts with per-vector masking. It holds a table of `NUM_VEC` vector entries, a read-only array of pending bits and a control word that carries a global enable and a function-wide mask. Software reaches all three through a simple register port that accepts aligned 32-bit and 64-bit accesses. Device logic raises one-cycle pulses on `trig`, one bit per vector.

When a vector is allowed to signal, its trigger becomes a message: the entry's 64-bit address and 32-bit data, sent on a valid/ready output. When a vector is blocked, the trigger sets that vector's pending bit and no message is sent. A vector is blocked while its own mask is set, while the function mask is set, or while enable is clear. Clearing a vector's mask, or clearing the function mask, releases the pending vectors that are now unblocked. They go out as messages in ascending index order, and their pending bits clear.

The message port follows valid/ready rules. The block holds `msg_valid`, `msg_addr` and `msg_data` steady until `msg_ready` is seen high at a clock edge. A message is taken on every edge where both are high. While the port is stalled, accepted sends wait in an internal queue of one request bit per vector. They are neither lost nor duplicated.

Top module: `msix_vec_ctrl`

## Requirements
- R1: After reset, every entry has its mask set and its address and data at zero. Enable, function mask and all pending bits are zero, and `msg_valid` is low.
- R2: `reg_addr[15:14]`=00 selects the table, where entry v starts at byte v*16. A 32-bit access at entry offset 0x0, 0x4, 0x8 or 0xC reaches address low, address high, data and the mask (bit 0 of the word, other bits read zero). A 64-bit access at 0x0 reaches {address high, address low}. A 64-bit access at 0x8 reaches {mask word, data}. Any other offset, or an entry index of `NUM_VEC` or more, reads zero and ignores writes.
- R3: `reg_addr[15:14]`=10 at offset 0 is the control word. Bit 15 is enable and bit 14 is the function mask, and only these two bits are writable. Bits 10:0 read `NUM_VEC`-1, and all other bits read zero.
- R4: `reg_addr[15:14]`=01 is the pending array of 64-bit words. The pending bit for vector v is bit v%64 of the word at byte (v/64)*8. A 32-bit read at word offset 4 returns the upper half of the word in `reg_rdata[31:0]`. Writes to this region change nothing.
- R5: A trigger for a vector that is unblocked, with the port idle and ready, puts its message on the port with `msg_valid` high after the second rising edge that follows the trigger's sampling edge.
- R6: A trigger for a blocked vector (entry mask set, function mask set or enable clear) sets its pending bit and sends no message.
- R7: With enable set and the function mask clear, a write that clears a pending vector's mask sends that vector's message and clears its pending bit.
- R8: When the function mask goes from 1 to 0, every pending vector whose own mask is clear is sent, lowest index first and one per accepted cycle. Vectors still masked stay pending.
- R9: A vector whose 64-bit address is zero is never emitted. A send request for it is consumed without a message.
- R10: While `msg_valid` is high and `msg_ready` is low, valid, address and data hold steady.
- R11: Triggers that arrive in the same cycle, or while the port is stalled, are all delivered, lowest vector index first.
- R12: `reg_rvalid` rises exactly one edge after a sampled `reg_rd`, and `reg_rdata` holds the value the target had before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wide | input | 1 | 1 for a 64-bit access, 0 for a 32-bit access |
| reg_addr | input | AW | Byte address; the top two bits select the region |
| reg_wdata | input | 64 | Write data; a 32-bit access uses bits 31:0 |
| reg_rvalid | output | 1 | Read data valid |
| reg_rdata | output | 64 | Read data; a 32-bit read returns in bits 31:0 |
| trig | input | NUM_VEC | Per-vector interrupt event pulses |
| msg_valid | output | 1 | Message valid |
| msg_ready | input | 1 | Receiver accepts the message |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |

## Verification
Each result has a fixed due time. Register effects and read data are due one edge after the access is sampled. A message from a trigger or from an unmask is due after two edges: one edge moves the event into the request queue and the next loads the output stage. The bench drives inputs and samples outputs on falling edges, so it can check that `msg_valid` is still low after the first edge and high after the second. A logger clocked on the rising edge records every accepted message. Order and loss checks for flushes and stalls are made against that log, with a fixed cycle margin after the last message is due.

// File: rtl/msix_ctrl_pkg.sv
package msix_ctrl_pkg;
  typedef enum logic [1:0] {
    RGN_TABLE = 2'b00,
    RGN_PEND  = 2'b01,
    RGN_CTRL  = 2'b10,
    RGN_RSVD  = 2'b11
  } region_e;

  localparam int CTL_EN_BIT = 15;
  localparam int CTL_FM_BIT = 14;
  localparam int SIZE_W     = 11;

  localparam logic [3:0] OFF_ALO = 4'h0;
  localparam logic [3:0] OFF_AHI = 4'h4;
  localparam logic [3:0] OFF_DAT = 4'h8;
  localparam logic [3:0] OFF_CTL = 4'hC;
endpackage

// File: rtl/msix_vec_table.sv
module msix_vec_table
  import msix_ctrl_pkg::*;
#(
  parameter int NV  = 40,
  parameter int IXW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wide,
  input  logic [IXW-1:0]  acc_idx,
  input  logic [3:0]      acc_off,
  input  logic [63:0]     wdata,
  output logic [63:0]     rd_word,
  input  logic [IXW-1:0]  sel_idx,
  output logic [63:0]     sel_addr,
  output logic [31:0]     sel_data,
  output logic [NV-1:0]   vmask_q,
  output logic [NV-1:0]   vmask_d
);
  logic [31:0] alo_r [NV];
  logic [31:0] ahi_r [NV];
  logic [31:0] dat_r [NV];
  logic [NV-1:0] mask_r;

  logic idx_ok, w_alo, w_ahi, w_dat, w_ctl, ctl_bit;
  logic [31:0] ahi_val;

  assign idx_ok  = (32'(acc_idx) < NV);
  assign w_alo   = wr_en && idx_ok && (acc_off == OFF_ALO);
  assign w_ahi   = wr_en && idx_ok &&
                   ((!wide && acc_off == OFF_AHI) || (wide && acc_off == OFF_ALO));
  assign w_dat   = wr_en && idx_ok && (acc_off == OFF_DAT);
  assign w_ctl   = wr_en && idx_ok &&
                   ((!wide && acc_off == OFF_CTL) || (wide && acc_off == OFF_DAT));
  assign ahi_val = wide ? wdata[63:32] : wdata[31:0];
  assign ctl_bit = wide ? wdata[32] : wdata[0];

  always_comb begin
    for (int v = 0; v < NV; v++) begin
      vmask_d[v] = (w_ctl && acc_idx == IXW'(v)) ? ctl_bit : mask_r[v];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mask_r <= '1;
    else        mask_r <= vmask_d;
  end

  for (genvar v = 0; v < NV; v++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        alo_r[v] <= '0;
        ahi_r[v] <= '0;
        dat_r[v] <= '0;
      end else if (acc_idx == IXW'(v)) begin
        if (w_alo) alo_r[v] <= wdata[31:0];
        if (w_ahi) ahi_r[v] <= ahi_val;
        if (w_dat) dat_r[v] <= wdata[31:0];
      end
    end

    AST_ENTRY_MASK_WR: assert property (@(posedge clk) disable iff (!rst_n)
      (w_ctl && acc_idx == IXW'(v)) |=> (vmask_q[v] == $past(ctl_bit)))
      else $error("entry mask write lost"); // R2
  end

  assign vmask_q = mask_r;

  always_comb begin
    rd_word = '0;
    if (idx_ok) begin
      if (!wide) begin
        case (acc_off)
          OFF_ALO: rd_word = {32'b0, alo_r[acc_idx]};
          OFF_AHI: rd_word = {32'b0, ahi_r[acc_idx]};
          OFF_DAT: rd_word = {32'b0, dat_r[acc_idx]};
          OFF_CTL: rd_word = {63'b0, mask_r[acc_idx]};
          default: rd_word = '0;
        endcase
      end else begin
        case (acc_off)
          OFF_ALO: rd_word = {ahi_r[acc_idx], alo_r[acc_idx]};
          OFF_DAT: rd_word = {31'b0, mask_r[acc_idx], dat_r[acc_idx]};
          default: rd_word = '0;
        endcase
      end
    end
  end

  always_comb begin
    sel_addr = '0;
    sel_data = '0;
    if (32'(sel_idx) < NV) begin
      sel_addr = {ahi_r[sel_idx], alo_r[sel_idx]};
      sel_data = dat_r[sel_idx];
    end
  end
endmodule

// File: rtl/msix_pend_arb.sv
module msix_pend_arb #(
  parameter int NV  = 40,
  parameter int IXW = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NV-1:0]  trig,
  input  logic [NV-1:0]  eff_mask_d,
  input  logic [NV-1:0]  flush_sel,
  output logic [IXW-1:0] sel_idx,
  input  logic [63:0]    sel_addr,
  input  logic [31:0]    sel_data,
  output logic [NV-1:0]  pend_q,
  output logic           msg_valid,
  input  logic           msg_ready,
  output logic [63:0]    msg_addr,
  output logic [31:0]    msg_data
);
  logic [NV-1:0] pend_r, sreq_r, pend_d, sreq_d;
  logic [NV-1:0] moved, cand, gnt_clr, sreq_raw, demote;
  logic [IXW-1:0] gnt_idx;
  logic gnt_any, can_load, addr_nz;
  logic out_v;
  logic [63:0] out_addr;
  logic [31:0] out_data;

  assign moved = pend_r & flush_sel & ~eff_mask_d;
  assign cand  = sreq_r & ~eff_mask_d;

  always_comb begin
    gnt_any = 1'b0;
    gnt_idx = '0;
    for (int v = NV-1; v >= 0; v--) begin
      if (cand[v]) begin
        gnt_any = 1'b1;
        gnt_idx = IXW'(v);
      end
    end
  end

  assign sel_idx  = gnt_idx;
  assign can_load = !out_v || msg_ready;
  assign addr_nz  = |sel_addr;
  assign gnt_clr  = (can_load && gnt_any) ? (NV'(1) << gnt_idx) : '0;
  assign sreq_raw = (sreq_r & ~gnt_clr) | (trig & ~eff_mask_d) | moved;
  assign demote   = sreq_raw & eff_mask_d;
  assign sreq_d   = sreq_raw & ~eff_mask_d;
  assign pend_d   = (pend_r & ~moved) | (trig & eff_mask_d) | demote;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_r   <= '0;
      sreq_r   <= '0;
      out_v    <= 1'b0;
      out_addr <= '0;
      out_data <= '0;
    end else begin
      pend_r <= pend_d;
      sreq_r <= sreq_d;
      if (can_load) begin
        out_v <= gnt_any && addr_nz;
        if (gnt_any) begin
          out_addr <= sel_addr;
          out_data <= sel_data;
        end
      end
    end
  end

  assign pend_q    = pend_r;
  assign msg_valid = out_v;
  assign msg_addr  = out_addr;
  assign msg_data  = out_data;

  AST_MSG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)))
    else $error("message changed under back-pressure"); // R10

  AST_NO_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_addr != 64'd0))
    else $error("zero-address message emitted"); // R9

  for (genvar v = 0; v < NV; v++) begin : g_chk
    AST_MASKED_TRIG_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (trig[v] && eff_mask_d[v]) |=> pend_q[v])
      else $error("blocked trigger not recorded"); // R6

    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_sel[v] && !eff_mask_d[v]) |=> !pend_q[v])
      else $error("flushed vector still pending"); // R7
  end
endmodule

// File: rtl/msix_vec_ctrl.sv
module msix_vec_ctrl
  import msix_ctrl_pkg::*;
#(
  parameter int NUM_VEC = 40,
  parameter int AW      = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic               reg_wide,
  input  logic [AW-1:0]      reg_addr,
  input  logic [63:0]        reg_wdata,
  output logic               reg_rvalid,
  output logic [63:0]        reg_rdata,
  input  logic [NUM_VEC-1:0] trig,
  output logic               msg_valid,
  input  logic               msg_ready,
  output logic [63:0]        msg_addr,
  output logic [31:0]        msg_data
);
  localparam int IXW  = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;
  localparam int OW   = AW - 2;
  localparam int EIW  = OW - 4;
  localparam int PWIW = OW - 3;
  localparam int NW   = (NUM_VEC + 63) / 64;

  region_e        region;
  logic [OW-1:0]  roff;
  logic [EIW-1:0] ent_full;
  logic [PWIW-1:0] pw_idx;
  logic ent_ok, tbl_wr, ctl_wr;
  logic en_q, fm_q, en_d, fm_d;
  logic [NUM_VEC-1:0] vmask_q, vmask_d, eff_mask_d, flush_sel, pend_q;
  logic [IXW-1:0] sel_idx;
  logic [63:0] sel_addr, tbl_word, pend_word, rd_mux;
  logic [31:0] sel_data;
  logic [NW*64-1:0] pend_pad;
  logic [15:0] ctl_word;

  assign region   = region_e'(reg_addr[AW-1:AW-2]);
  assign roff     = reg_addr[OW-1:0];
  assign ent_full = roff[OW-1:4];
  assign pw_idx   = roff[OW-1:3];
  assign ent_ok   = (32'(ent_full) < NUM_VEC);
  assign tbl_wr   = reg_wr && (region == RGN_TABLE) && ent_ok;
  assign ctl_wr   = reg_wr && (region == RGN_CTRL) && (roff == '0);

  // control word: enable and function mask
  assign en_d = ctl_wr ? reg_wdata[CTL_EN_BIT] : en_q;
  assign fm_d = ctl_wr ? reg_wdata[CTL_FM_BIT] : fm_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      fm_q <= 1'b0;
    end else begin
      en_q <= en_d;
      fm_q <= fm_d;
    end
  end

  assign ctl_word   = {en_q, fm_q, 3'b000, SIZE_W'(NUM_VEC - 1)};
  assign eff_mask_d = vmask_d | {NUM_VEC{fm_d | ~en_d}};
  assign flush_sel  = (vmask_q & ~vmask_d) | {NUM_VEC{fm_q & ~fm_d}};

  msix_vec_table #(.NV(NUM_VEC), .IXW(IXW)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (tbl_wr),
    .wide     (reg_wide),
    .acc_idx  (ent_full[IXW-1:0]),
    .acc_off  (roff[3:0]),
    .wdata    (reg_wdata),
    .rd_word  (tbl_word),
    .sel_idx  (sel_idx),
    .sel_addr (sel_addr),
    .sel_data (sel_data),
    .vmask_q  (vmask_q),
    .vmask_d  (vmask_d)
  );

  msix_pend_arb #(.NV(NUM_VEC), .IXW(IXW)) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig       (trig),
    .eff_mask_d (eff_mask_d),
    .flush_sel  (flush_sel),
    .sel_idx    (sel_idx),
    .sel_addr   (sel_addr),
    .sel_data   (sel_data),
    .pend_q     (pend_q),
    .msg_valid  (msg_valid),
    .msg_ready  (msg_ready),
    .msg_addr   (msg_addr),
    .msg_data   (msg_data)
  );

  // pending array word select
  always_comb begin
    pend_pad = '0;
    pend_pad[NUM_VEC-1:0] = pend_q;
    pend_word = '0;
    for (int w = 0; w < NW; w++) begin
      if (32'(pw_idx) == w) pend_word = pend_pad[w*64 +: 64];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (region)
      RGN_TABLE: rd_mux = ent_ok ? tbl_word : '0;
      RGN_PEND: begin
        if (roff[2:0] == 3'd0)
          rd_mux = reg_wide ? pend_word : {32'b0, pend_word[31:0]};
        else if (!reg_wide && roff[2:0] == 3'd4)
          rd_mux = {32'b0, pend_word[63:32]};
      end
      RGN_CTRL: if (roff == '0) rd_mux = {48'b0, ctl_word};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rvalid <= 1'b0;
      reg_rdata  <= '0;
    end else begin
      reg_rvalid <= reg_rd;
      if (reg_rd) reg_rdata <= rd_mux;
    end
  end

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_rvalid)
    else $error("read data not returned"); // R12

  AST_CTL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (en_q == $past(reg_wdata[CTL_EN_BIT]) && fm_q == $past(reg_wdata[CTL_FM_BIT])))
    else $error("control write lost"); // R3
endmodule

// File: tb/msix_vec_ctrl_tb.sv
`timescale 1ns/1ps
module msix_vec_ctrl_tb;
  localparam int NV = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0, reg_wide = 1'b0;
  logic [15:0] reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic reg_rvalid;
  logic [63:0] reg_rdata;
  logic [NV-1:0] trig = '0;
  logic msg_valid, msg_ready = 1'b1;
  logic [63:0] msg_addr;
  logic [31:0] msg_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int nlog = 0;
  logic [31:0] log_data [64];
  logic [63:0] log_addr [64];

  always #2.5 clk = ~clk;

  msix_vec_ctrl #(.NUM_VEC(NV), .AW(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wide(reg_wide),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata),
    .trig(trig), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data)
  );

  always @(posedge clk) begin
    if (rst_n && msg_valid && msg_ready && nlog < 64) begin
      log_data[nlog] = msg_data;
      log_addr[nlog] = msg_addr;
      nlog = nlog + 1;
    end
  end

  function automatic logic [63:0] vaddr(input int v);
    return {32'h0000_00AB, 32'hFEE0_0000 | 32'(v << 4)};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [63:0] d, input bit w);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_wide = w;
    @(negedge clk);
    reg_wr = 1'b0; reg_wide = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input bit w, output logic [63:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a; reg_wide = w;
    @(negedge clk);
    reg_rd = 1'b0; reg_wide = 1'b0;
    d = reg_rdata;
  endtask

  task automatic fire(input logic [NV-1:0] bits);
    @(negedge clk);
    trig = bits;
    @(negedge clk);
    trig = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic prog(input int v);
    wr(16'(v*16 + 0), {32'b0, vaddr(v)[31:0]}, 1'b0);
    wr(16'(v*16 + 4), {32'b0, vaddr(v)[63:32]}, 1'b0);
    wr(16'(v*16 + 8), 64'(32'hD000 + v), 1'b0);
  endtask

  task automatic t_reset();
    logic [63:0] d;
    chk("R1 msg_valid after reset", 64'(msg_valid), 64'd0);
    rd(16'h8000, 1'b0, d); chk("R1/R3 control word after reset", d, 64'h27);
    rd(16'h003C, 1'b0, d); chk("R1 entry 3 mask after reset", d, 64'd1);
    rd(16'h0030, 1'b1, d); chk("R1 entry 3 address after reset", d, 64'd0);
    rd(16'h4000, 1'b1, d); chk("R1 pending word after reset", d, 64'd0);
  endtask

  task automatic t_table();
    logic [63:0] d;
    prog(2);
    rd(16'h0020, 1'b1, d); chk("R2 wide address read", d, vaddr(2));
    wr(16'h0028, {32'h1, 32'hD002}, 1'b1);
    rd(16'h002C, 1'b0, d); chk("R2 narrow mask read", d, 64'd1);
    rd(16'h0028, 1'b0, d); chk("R2 narrow data read", d, 64'hD002);
    rd(16'h0028, 1'b1, d); chk("R2 wide mask:data read", d, {32'h1, 32'hD002});
    rd(16'h0024, 1'b1, d); chk("R2 wide read at offset 4 is zero", d, 64'd0);
    wr(16'h0022, 64'hFFFF_FFFF, 1'b0);
    wr(16'h0024, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
    rd(16'h0020, 1'b1, d); chk("R2 misaligned writes ignored", d, vaddr(2));
    wr(16'(NV*16), 64'h1234, 1'b0);
    rd(16'(NV*16), 1'b0, d); chk("R2 entry beyond table reads zero", d, 64'd0);
  endtask

  task automatic t_ctrl();
    logic [63:0] d;
    wr(16'h8000, 64'hFFFF, 1'b0);
    rd(16'h8000, 1'b0, d); chk("R3 only bits 15:14 writable", d, 64'hC027);
    wr(16'h8000, 64'h8000, 1'b0);
    rd(16'h8000, 1'b0, d); chk("R3 enable only", d, 64'h8027);
  endtask

  task automatic t_direct();
    int n0;
    prog(3);
    wr(16'h003C, 64'd0, 1'b0);
    n0 = nlog;
    @(negedge clk); trig[3] = 1'b1;
    @(negedge clk); trig = '0;
    chk("R5 no message one edge after trigger", 64'(msg_valid), 64'd0);
    @(negedge clk);
    chk("R5 message valid two edges after trigger", 64'(msg_valid), 64'd1);
    chk("R5 message address", msg_addr, vaddr(3));
    chk("R5 message data", 64'(msg_data), 64'hD003);
    @(negedge clk);
    chk("R5 single message", 64'(nlog - n0), 64'd1);
  endtask

  task automatic t_masked();
    logic [63:0] d;
    int n0;
    prog(1);
    n0 = nlog;
    fire(NV'(1) << 1);
    idle(4);
    chk("R6 masked trigger sends nothing", 64'(nlog - n0), 64'd0);
    rd(16'h4000, 1'b1, d); chk("R6 pending bit 1 set", d, 64'h2);
    wr(16'h4000, 64'd0, 1'b1);
    wr(16'h4000, 64'd0, 1'b0);
    rd(16'h4000, 1'b1, d); chk("R4 pending array ignores writes", d, 64'h2);
    wr(16'h001C, 64'd0, 1'b0);
    chk("R7 no message one edge after unmask", 64'(msg_valid), 64'd0);
    @(negedge clk);
    chk("R7 unmask sends pending message", 64'(msg_data), 64'hD001);
    chk("R7 unmask message valid", 64'(msg_valid), 64'd1);
    rd(16'h4000, 1'b1, d); chk("R7 pending bit cleared", d, 64'd0);
  endtask

  task automatic t_upper();
    logic [63:0] d;
    prog(35);
    fire(NV'(1) << 35);
    idle(2);
    rd(16'h4004, 1'b0, d); chk("R4 upper half holds bit 35", d, 64'h8);
    rd(16'h4000, 1'b0, d); chk("R4 lower half", d, 64'd0);
    rd(16'h4000, 1'b1, d); chk("R4 wide word", d, 64'h8_0000_0000);
  endtask

  task automatic t_fmask();
    logic [63:0] d;
    int n0;
    prog(4); prog(5);
    wr(16'h002C, 64'd0, 1'b0);
    wr(16'h004C, 64'd0, 1'b0);
    wr(16'h8000, 64'hC000, 1'b0);
    n0 = nlog;
    fire((NV'(1) << 4) | (NV'(1) << 2) | (NV'(1) << 5));
    idle(3);
    chk("R6 function mask blocks messages", 64'(nlog - n0), 64'd0);
    rd(16'h4000, 1'b1, d); chk("R6 pending under function mask", d, 64'h8_0000_0034);
    wr(16'h8000, 64'h8000, 1'b0);
    idle(4);
    chk("R8 two vectors flushed", 64'(nlog - n0), 64'd2);
    chk("R8 first flushed is vector 2", 64'(log_data[n0]), 64'hD002);
    chk("R8 second flushed is vector 4", 64'(log_data[n0+1]), 64'hD004);
    rd(16'h4000, 1'b1, d); chk("R8 masked vectors stay pending", d, 64'h8_0000_0020);
  endtask

  task automatic t_stall();
    int n0;
    n0 = nlog;
    msg_ready = 1'b0;
    fire((NV'(1) << 4) | (NV'(1) << 2));
    @(negedge clk);
    chk("R10 valid under stall", 64'(msg_valid), 64'd1);
    chk("R11 lowest index first", 64'(msg_data), 64'hD002);
    idle(3);
    chk("R10 valid held", 64'(msg_valid), 64'd1);
    chk("R10 data held", 64'(msg_data), 64'hD002);
    chk("R10 address held", msg_addr, vaddr(2));
    msg_ready = 1'b1;
    idle(4);
    chk("R11 both delivered", 64'(nlog - n0), 64'd2);
    chk("R11 second is vector 4", 64'(log_data[n0+1]), 64'hD004);
  endtask

  task automatic t_zero();
    logic [63:0] d;
    int n0;
    wr(16'h006C, 64'd0, 1'b0);
    n0 = nlog;
    fire(NV'(1) << 6);
    idle(4);
    chk("R9 zero address not emitted", 64'(nlog - n0), 64'd0);
    rd(16'h4000, 1'b1, d); chk("R9 zero address not pending", d, 64'h8_0000_0020);
  endtask

  task automatic t_disable();
    logic [63:0] d;
    int n0;
    wr(16'h8000, 64'd0, 1'b0);
    n0 = nlog;
    fire(NV'(1) << 3);
    idle(4);
    chk("R6 enable clear sends nothing", 64'(nlog - n0), 64'd0);
    rd(16'h4000, 1'b1, d); chk("R6 enable clear records pending", d, 64'h8_0000_0028);
  endtask

  task automatic t_read_timing();
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 16'h8000; reg_wide = 1'b0;
    @(negedge clk);
    reg_rd = 1'b0;
    chk("R12 rvalid one edge after read", 64'(reg_rvalid), 64'd1);
    chk("R12 read data", reg_rdata, 64'h27);
    @(negedge clk);
    chk("R12 rvalid drops", 64'(reg_rvalid), 64'd0);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_table();
    t_ctrl();
    t_direct();
    t_masked();
    t_upper();
    t_fmask();
    t_stall();
    t_zero();
    t_disable();
    t_read_timing();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule